// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a simple valid/ready host port and an external asynchronous static RAM that has a 16-bit data bus split into two byte lanes, each with its own active-low enable. Each host request names one word and a lane mask. The controller turns it into a timed sequence of active-low chip select, write strobe, output enable and lane enables. For writes it also sets the data-drive enable that controls the bidirectional pad.

Every timing window is given in nanoseconds as a parameter. The controller converts each one into a whole number of clock cycles, rounding up against the clock period. A write has three phases: setup, strobe and recovery. A read holds the output enable low for a single access window and captures the lanes on its last edge. After a read, a write waits out the memory's output-release time before the controller drives the bus again.

Top module: `asram_ctrl`

## Requirements
- R1: While idle (and during reset), `req_ready` is 1, `mem_ce_n`, `mem_we_n`, `mem_oe_n` are 1, both bits of `mem_be_n` are 1 and `mem_dq_oe` is 0.
- R2: A write updates only the lanes whose mask bit is 1. Mask bit l selects data bits 8l+7..8l and drives `mem_be_n[l]` low. A lane whose bit is 0 keeps its old memory contents, and a mask of 0 changes nothing.
- R3: On every write, `mem_we_n` stays low for at least ceil(40/T) cycles, where T is the clock period in ns. Before the strobe rises, chip select is low with a stable address for at least ceil(45/T) cycles and write data is driven stable for at least ceil(25/T) cycles.
- R4: On every write with a non-zero mask, the lane enables are low for at least ceil(50/T) cycles before the write strobe rises.
- R5: The data bus is never driven while `mem_oe_n` is 0.
- R6: A read's `rsp_valid` is high for exactly one cycle. It appears max(ceil(55/T), ceil(25/T)) clock edges after the accepting edge, which is 3 edges at 50 MHz.
- R7: On a read, a lane whose mask bit is 0 returns 0 in `rsp_rdata`, and a lane whose bit is 1 returns the stored byte.
- R8: After a read, the bus is not driven until `mem_oe_n` has been high for at least max(1, ceil(25/T)) cycles. A write that follows a read therefore returns `req_ready` that many cycles later than a write that follows a write.
- R9: Consecutive writes end at least ceil(55/T) cycles apart. `mem_we_n` stays high for at least two cycles after each strobe, and a write returns `req_ready` 4 edges after acceptance at 50 MHz when no read preceded it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle, accepts a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 16 | Write data |
| req_bmask | input | 2 | Lane mask, bit l selects byte lane l |
| rsp_valid | output | 1 | One-cycle read response strobe |
| rsp_rdata | output | 16 | Read data, unselected lanes zero |
| mem_addr | output | 17 | Memory address |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_be_n | output | 2 | Lane enables, active low |
| mem_dq_out | output | 16 | Data toward the memory |
| mem_dq_oe | output | 1 | Pad drive enable for `mem_dq_out` |
| mem_dq_in | input | 16 | Data from the memory |

## Verification
A read response is due 3 rising edges after the edge that accepts it. A write makes `req_ready` high again 4 edges after acceptance, or 6 edges when a read came just before it. The bench drives every request on a falling edge and counts rising edges from acceptance to the first falling edge where `req_ready` is back. It compares that count and the edge on which `rsp_valid` appears against these numbers. The memory model samples strobes on falling edges. It releases real data only after the access window has run, so an early capture returns a garbage pattern. It measures strobe, setup and release windows in whole cycles.

// File: rtl/asram_pkg.sv
package asram_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_TURN,
      ST_WSET,
      ST_WPUL,
      ST_WREC,
      ST_RACC
   } asram_state_e;

   function automatic int unsigned cdiv(input int unsigned num, input int unsigned den);
      return (num + den - 1) / den;
   endfunction

   function automatic int unsigned umax(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/asram_phase_timer.sv
module asram_phase_timer #(
   parameter int unsigned CW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          expired
);

   logic [CW-1:0] remain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         remain <= '0;
      else if (load)
         remain <= load_val;
      else if (remain != '0)
         remain <= remain - 1'b1;
   end

   assign expired = (remain == '0);

endmodule

// File: rtl/asram_byte_lane.sv
module asram_byte_lane #(
   parameter int unsigned LW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_load,
   input  logic [LW-1:0] wr_in,
   output logic [LW-1:0] wr_out,
   input  logic          rd_cap,
   input  logic          rd_on,
   input  logic [LW-1:0] rd_in,
   output logic [LW-1:0] rd_out
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         wr_out <= '0;
      else if (wr_load)
         wr_out <= wr_in;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rd_out <= '0;
      else if (rd_cap)
         rd_out <= rd_on ? rd_in : '0;
   end

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
   import asram_pkg::*;
#(
   parameter int unsigned ADDR_W        = 17,
   parameter int unsigned LANES         = 2,
   parameter int unsigned LANE_W        = 8,
   parameter int unsigned CLK_PERIOD_NS = 20,
   parameter int unsigned T_AA_NS       = 55,
   parameter int unsigned T_RC_NS       = 55,
   parameter int unsigned T_DOE_NS      = 25,
   parameter int unsigned T_PWE_NS      = 40,
   parameter int unsigned T_WC_NS       = 55,
   parameter int unsigned T_AW_NS       = 45,
   parameter int unsigned T_SD_NS       = 25,
   parameter int unsigned T_BW_NS       = 50,
   parameter int unsigned T_HZOE_NS     = 25
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      req_valid,
   output logic                      req_ready,
   input  logic                      req_write,
   input  logic [ADDR_W-1:0]         req_addr,
   input  logic [LANES*LANE_W-1:0]   req_wdata,
   input  logic [LANES-1:0]          req_bmask,
   output logic                      rsp_valid,
   output logic [LANES*LANE_W-1:0]   rsp_rdata,
   output logic [ADDR_W-1:0]         mem_addr,
   output logic                      mem_ce_n,
   output logic                      mem_we_n,
   output logic                      mem_oe_n,
   output logic [LANES-1:0]          mem_be_n,
   output logic [LANES*LANE_W-1:0]   mem_dq_out,
   output logic                      mem_dq_oe,
   input  logic [LANES*LANE_W-1:0]   mem_dq_in
);

   // ---- cycle counts derived from nanosecond windows ----
   localparam int unsigned CYC_AA   = cdiv(T_AA_NS,   CLK_PERIOD_NS);
   localparam int unsigned CYC_RC   = cdiv(T_RC_NS,   CLK_PERIOD_NS);
   localparam int unsigned CYC_DOE  = cdiv(T_DOE_NS,  CLK_PERIOD_NS);
   localparam int unsigned CYC_PWE  = cdiv(T_PWE_NS,  CLK_PERIOD_NS);
   localparam int unsigned CYC_WC   = cdiv(T_WC_NS,   CLK_PERIOD_NS);
   localparam int unsigned CYC_AW   = cdiv(T_AW_NS,   CLK_PERIOD_NS);
   localparam int unsigned CYC_SD   = cdiv(T_SD_NS,   CLK_PERIOD_NS);
   localparam int unsigned CYC_BW   = cdiv(T_BW_NS,   CLK_PERIOD_NS);
   localparam int unsigned CYC_HZOE = cdiv(T_HZOE_NS, CLK_PERIOD_NS);

   localparam int unsigned RD_CYC   = umax(1, umax(umax(CYC_AA, CYC_DOE), CYC_RC));
   localparam int unsigned WPUL_CYC = umax(1, umax(CYC_PWE, CYC_SD));
   localparam int unsigned W_NEED   = umax(CYC_AW, CYC_BW);
   localparam int unsigned WSET_CYC = (W_NEED > WPUL_CYC) ? (W_NEED - WPUL_CYC) : 1;
   localparam int unsigned WREC_CYC = (CYC_WC > WSET_CYC + WPUL_CYC + 1) ?
                                      (CYC_WC - WSET_CYC - WPUL_CYC) : 1;
   localparam int unsigned TURN_CYC = umax(1, CYC_HZOE);
   localparam int unsigned MAX_CYC  = umax(umax(RD_CYC, WPUL_CYC),
                                           umax(umax(WSET_CYC, WREC_CYC), TURN_CYC));
   localparam int unsigned CW       = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
   localparam int unsigned DATA_W   = LANES * LANE_W;

   // ---- elaboration-time parameter checks ----
   if (CLK_PERIOD_NS == 0) begin : g_bad_period
      $error("clock period must be non-zero");
   end
   if (LANES < 1 || LANE_W < 1) begin : g_bad_lanes
      $error("at least one lane of at least one bit is required");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("address width must be non-zero");
   end

   // ---- sequencer ----
   asram_state_e state, state_nx;
   logic          tm_load;
   logic [CW-1:0] tm_val;
   logic          tm_done;
   logic          accept;
   logic          capture;
   logic          last_was_read;
   logic [ADDR_W-1:0] addr_q;
   logic [LANES-1:0]  mask_q;

   assign req_ready = (state == ST_IDLE);
   assign accept    = req_valid && req_ready;
   assign capture   = (state == ST_RACC) && tm_done;

   asram_phase_timer #(.CW(CW)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tm_load),
      .load_val (tm_val),
      .expired  (tm_done)
   );

   always_comb begin
      state_nx = state;
      tm_load  = 1'b0;
      tm_val   = '0;
      unique case (state)
         ST_IDLE: begin
            if (req_valid) begin
               tm_load = 1'b1;
               if (!req_write) begin
                  state_nx = ST_RACC;
                  tm_val   = CW'(RD_CYC - 1);
               end else if (last_was_read) begin
                  state_nx = ST_TURN;
                  tm_val   = CW'(TURN_CYC - 1);
               end else begin
                  state_nx = ST_WSET;
                  tm_val   = CW'(WSET_CYC - 1);
               end
            end
         end
         ST_TURN: if (tm_done) begin
            state_nx = ST_WSET;
            tm_load  = 1'b1;
            tm_val   = CW'(WSET_CYC - 1);
         end
         ST_WSET: if (tm_done) begin
            state_nx = ST_WPUL;
            tm_load  = 1'b1;
            tm_val   = CW'(WPUL_CYC - 1);
         end
         ST_WPUL: if (tm_done) begin
            state_nx = ST_WREC;
            tm_load  = 1'b1;
            tm_val   = CW'(WREC_CYC - 1);
         end
         ST_WREC: if (tm_done) state_nx = ST_IDLE;
         ST_RACC: if (tm_done) state_nx = ST_IDLE;
         default: state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state         <= ST_IDLE;
         last_was_read <= 1'b0;
         addr_q        <= '0;
         mask_q        <= '0;
         rsp_valid     <= 1'b0;
      end else begin
         state     <= state_nx;
         rsp_valid <= capture;
         if (accept) begin
            last_was_read <= !req_write;
            addr_q        <= req_addr;
            mask_q        <= req_bmask;
         end
      end
   end

   // ---- strobe decode ----
   logic sel_active;
   assign sel_active = (state == ST_WSET) || (state == ST_WPUL) || (state == ST_RACC);
   assign mem_addr   = addr_q;
   assign mem_ce_n   = !sel_active;
   assign mem_we_n   = (state != ST_WPUL);
   assign mem_oe_n   = (state != ST_RACC);
   assign mem_dq_oe  = (state == ST_WSET) || (state == ST_WPUL);

   // ---- byte lanes ----
   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign mem_be_n[l] = !(sel_active && mask_q[l]);
      asram_byte_lane #(.LW(LANE_W)) u_lane (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_load (accept),
         .wr_in   (req_wdata[l*LANE_W +: LANE_W]),
         .wr_out  (mem_dq_out[l*LANE_W +: LANE_W]),
         .rd_cap  (capture),
         .rd_on   (mask_q[l]),
         .rd_in   (mem_dq_in[l*LANE_W +: LANE_W]),
         .rd_out  (rsp_rdata[l*LANE_W +: LANE_W])
      );
   end

   // ---- run-length observers for the timing properties ----
   localparam int unsigned RUNW = $clog2(MAX_CYC * 4 + 2) + 1;
   localparam logic [RUNW-1:0] RUN_SAT = '1;
   logic [RUNW-1:0] we_run, ce_run, be_run, oe_hi_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we_run    <= '0;
         ce_run    <= '0;
         be_run    <= '0;
         oe_hi_run <= RUN_SAT;
      end else begin
         we_run    <= mem_we_n ? '0 : ((we_run == RUN_SAT) ? we_run : we_run + 1'b1);
         ce_run    <= mem_ce_n ? '0 : ((ce_run == RUN_SAT) ? ce_run : ce_run + 1'b1);
         be_run    <= (&mem_be_n) ? '0 : ((be_run == RUN_SAT) ? be_run : be_run + 1'b1);
         oe_hi_run <= !mem_oe_n ? '0 : ((oe_hi_run == RUN_SAT) ? oe_hi_run : oe_hi_run + 1'b1);
      end
   end

   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && (&mem_be_n) && !mem_dq_oe));

   assert_strobe_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> (!mem_ce_n && mem_dq_oe));

   assert_we_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (we_run >= RUNW'(CYC_PWE)));

   assert_addr_setup_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (ce_run >= RUNW'(CYC_AW)));

   assert_lane_setup_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(mem_we_n) && $past(~&mem_be_n)) |-> (be_run >= RUNW'(CYC_BW)));

   assert_no_contention_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> mem_oe_n);

   assert_rsp_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   assert_turnaround_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_dq_oe) |-> (oe_hi_run >= RUNW'(TURN_CYC)));

   assert_we_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |=> mem_we_n);

endmodule

// File: tb/tb_asram_ctrl.sv
module tb_asram_ctrl;

   localparam int CLK_NS = 20;
   function automatic int cd(input int ns); return (ns + CLK_NS - 1) / CLK_NS; endfunction
   function automatic int mx(input int a, input int b); return (a > b) ? a : b; endfunction

   localparam int AA_C   = cd(55);
   localparam int RD_C   = mx(cd(55), cd(25));
   localparam int PWE_C  = cd(40);
   localparam int AW_C   = cd(45);
   localparam int SD_C   = cd(25);
   localparam int BW_C   = cd(50);
   localparam int WC_C   = cd(55);
   localparam int TURN_C = mx(1, cd(25));
   localparam int WR_LAT = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [16:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic [1:0]  req_bmask = '0;
   logic        req_ready, rsp_valid;
   logic [15:0] rsp_rdata;
   logic [16:0] mem_addr;
   logic        mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
   logic [1:0]  mem_be_n;
   logic [15:0] mem_dq_out, mem_dq_in;

   int checks = 0, fails = 0;

   always #(CLK_NS/2) clk = ~clk;

   asram_ctrl dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_bmask(req_bmask),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
      .mem_oe_n(mem_oe_n), .mem_be_n(mem_be_n), .mem_dq_out(mem_dq_out),
      .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // ---- memory model ----
   logic [15:0] mem_m [64];
   logic [15:0] exp_m [64];
   function automatic logic [15:0] init_word(input int i);
      return 16'(i * 16'h0907) ^ 16'hC35A;
   endfunction

   int   we_run = 0, ce_run = 0, be_run = 0, ds_run = 0, oe_hi = 15, rd_age = 0, since_end = 99;
   bit   ovl_prev = 0, ovl_now;
   logic [16:0] last_addr = '0, rd_addr = '0;
   logic [15:0] last_dq = '0, lat_dq = '0;
   logic [5:0]  lat_addr = '0;
   logic [1:0]  lat_be = 2'b11;

   always_comb begin
      for (int l = 0; l < 2; l++)
         mem_dq_in[l*8 +: 8] = (!mem_ce_n && !mem_oe_n && mem_we_n && !mem_be_n[l] && rd_age >= AA_C)
                               ? mem_m[mem_addr[5:0]][l*8 +: 8] : 8'hA5;
   end

   always @(negedge clk) begin
      if (rst_n) begin
         ovl_now = !mem_ce_n && !mem_we_n;
         if (ovl_prev && !ovl_now) begin
            chk(we_run >= PWE_C, "R3 strobe width", we_run, PWE_C);
            chk(ce_run >= AW_C, "R3 address setup", ce_run, AW_C);
            chk(ds_run >= SD_C, "R3 data setup", ds_run, SD_C);
            if (lat_be != 2'b11) chk(be_run >= BW_C, "R4 lane setup", be_run, BW_C);
            chk(since_end >= WC_C, "R9 write cycle", since_end, WC_C);
            for (int l = 0; l < 2; l++)
               if (!lat_be[l]) mem_m[lat_addr][l*8 +: 8] = lat_dq[l*8 +: 8];
            since_end = 0;
         end
         if (ovl_now) begin
            lat_addr = mem_addr[5:0];
            lat_be   = mem_be_n;
            lat_dq   = mem_dq_out;
            chk(mem_dq_oe, "R3 data driven during strobe", mem_dq_oe, 1);
         end
         if (mem_dq_oe) begin
            chk(mem_oe_n, "R5 drive with outputs on", mem_oe_n, 1);
            chk(oe_hi >= TURN_C, "R8 release window", oe_hi, TURN_C);
         end
         we_run = mem_we_n ? 0 : we_run + 1;
         ce_run = mem_ce_n ? 0 : ((mem_addr == last_addr && ce_run > 0) ? ce_run + 1 : 1);
         be_run = (&mem_be_n) ? 0 : be_run + 1;
         ds_run = !mem_dq_oe ? 0 : ((mem_dq_out == last_dq && ds_run > 0) ? ds_run + 1 : 1);
         oe_hi  = !mem_oe_n ? 0 : ((oe_hi < 15) ? oe_hi + 1 : 15);
         if (!mem_ce_n && !mem_oe_n && mem_we_n)
            rd_age = (rd_age > 0 && mem_addr == rd_addr) ? rd_age + 1 : 1;
         else
            rd_age = 0;
         if (since_end < 99) since_end++;
         rd_addr   = mem_addr;
         last_addr = mem_addr;
         last_dq   = mem_dq_out;
         ovl_prev  = ovl_now;
      end
   end

   task automatic check_quiet(input string tag);
      chk(req_ready && mem_ce_n && mem_we_n && mem_oe_n && mem_be_n == 2'b11 && !mem_dq_oe,
          tag, {req_ready, mem_ce_n, mem_we_n, mem_oe_n, mem_be_n, mem_dq_oe}, 7'h7E);
   endtask

   // Issue one request at a falling edge, count rising edges until ready returns.
   task automatic do_op(input bit wr, input int a, input logic [15:0] d, input logic [1:0] m,
                        output int lat, output int rsp_at, output int pulses, output logic [15:0] rd);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = 17'(a); req_wdata = d; req_bmask = m;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      lat = 0; rsp_at = -1; pulses = 0; rd = '0;
      while (!req_ready && lat < 50) begin
         if (rsp_valid) begin pulses++; rsp_at = lat; rd = rsp_rdata; end
         @(negedge clk);
         lat++;
      end
      if (rsp_valid) begin pulses++; rsp_at = lat; rd = rsp_rdata; end
      @(negedge clk);
      if (rsp_valid) pulses++;
   endtask

   task automatic do_write(input int a, input logic [15:0] d, input logic [1:0] m, input int exp_lat);
      int lat, at, p; logic [15:0] rd;
      do_op(1'b1, a, d, m, lat, at, p, rd);
      for (int l = 0; l < 2; l++) if (m[l]) exp_m[a][l*8 +: 8] = d[l*8 +: 8];
      if (exp_lat == WR_LAT) chk(lat == exp_lat, "R9 write latency", lat, exp_lat);
      else                   chk(lat == exp_lat, "R8 write after read latency", lat, exp_lat);
      check_quiet("R1 idle after write");
   endtask

   task automatic do_read(input int a, input logic [1:0] m);
      int lat, at, p; logic [15:0] rd, ex;
      do_op(1'b0, a, 16'h0, m, lat, at, p, rd);
      ex = '0;
      for (int l = 0; l < 2; l++) if (m[l]) ex[l*8 +: 8] = exp_m[a][l*8 +: 8];
      chk(at == RD_C, "R6 response edge", at, RD_C);
      chk(p == 1, "R6 single pulse", p, 1);
      if (m == 2'b11) chk(rd == ex, "R2 stored word", rd, ex);
      else            chk(rd == ex, "R7 lane masking", rd, ex);
   endtask

   initial begin
      for (int i = 0; i < 64; i++) begin mem_m[i] = init_word(i); exp_m[i] = init_word(i); end
      repeat (4) @(negedge clk);
      check_quiet("R1 reset state");
      chk(!rsp_valid, "R1 reset response", rsp_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check_quiet("R1 after reset");
      // sweep every mask over 16 words
      for (int a = 0; a < 16; a++)
         for (int m = 0; m < 4; m++)
            do_write(a, 16'(a * 16'h1111 + m * 16'h0F0F) ^ 16'h8421, 2'(m), WR_LAT);
      for (int a = 0; a < 16; a++)
         for (int m = 0; m < 4; m++)
            do_read(a, 2'(m));
      // read/write alternation exercises the turnaround
      for (int a = 16; a < 32; a++) begin
         do_read(a, 2'b11);
         do_write(a, 16'(a * 16'h3C5) ^ 16'h00FF, 2'(a % 4), WR_LAT + TURN_C);
         do_read(a, 2'b11);
         do_read(a, 2'(3 - a % 4));
      end
      // model contents must equal the bench's own expectation
      for (int a = 0; a < 32; a++)
         chk(mem_m[a] == exp_m[a], "R2 memory image", mem_m[a], exp_m[a]);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog R1 actual=%0h expected=%0h", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

endmodule